// File: doc/BRIEF.md
# Floating-Point Data Class Tester

This block decides whether a binary32 or binary64 operand falls into any of a set of value classes that a caller picks with a bit mask. It sorts the operand into one of six classes: zero, normal, subnormal, infinity, quiet NaN or signaling NaN. The operand's sign then selects one of the two mask bits that belong to that class. The answer is a 2-bit condition code. It is 1 when the selected mask bit is set and 0 when it is clear.

A request is one clock cycle with `in_valid` high. It carries the operand, a format select and the mask. The registered result appears on the next cycle, with `out_valid` high. Between requests the condition code keeps its last value. The block only classifies values. It raises no exceptions and handles no format wider than 64 bits.

Top module: `fp_dclass_test`

## Requirements
- R1: While `rst` is high at a rising edge, `cc` becomes 0 and `out_valid` becomes 0 after that edge.
- R2: `out_valid` equals the `in_valid` of the previous cycle. `cc` is loaded only on a cycle with `in_valid` high; otherwise it holds its value.
- R3: A zero operand (exponent all zeros, fraction zero) tests mask bit 11 when positive and bit 10 when negative.
- R4: A normal operand (exponent neither all zeros nor all ones) tests bit 9 when positive and bit 8 when negative.
- R5: A subnormal operand (exponent all zeros, fraction non-zero) tests bit 7 when positive and bit 6 when negative.
- R6: An infinity (exponent all ones, fraction zero) tests bit 5 when positive and bit 4 when negative.
- R7: A quiet NaN (exponent all ones, fraction MSB set) tests only bit 3 when positive and bit 2 when negative.
- R8: A signaling NaN (exponent all ones, fraction MSB clear, fraction non-zero) tests only bit 1 when positive and bit 0 when negative.
- R9: `cc` is 1 when the selected mask bit is 1 and 0 otherwise. `cc` never takes the values 2 or 3. A mask with bits 11:0 all clear always gives 0, and a mask with bits 11:0 all set always gives 1.
- R10: With `fmt` = 0 the operand is binary32 in `operand[31:0]`, and bits 63:32 have no effect. With `fmt` = 1 the operand is binary64 in `operand[63:0]`.
- R11: Mask bits at and above bit 12 have no effect on `cc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe; the inputs below are sampled while it is high |
| fmt | input | 1 | 0 = binary32 in bits 31:0, 1 = binary64 |
| operand | input | 64 | Value to classify |
| mask | input | MASK_W (16) | Class/sign selection mask; only bits 11:0 are used |
| out_valid | output | 1 | High one cycle after a request |
| cc | output | 2 | Condition code, 0 or 1 |

## Verification
Both `cc` and `out_valid` are due in the cycle after the rising edge that samples a request, because exactly one register stage lies between them and the inputs. The bench drives each request on a falling edge and reads the outputs on the next falling edge, which falls half a period after the edge that loads them. Idle cycles are checked the same way, at the next falling edge: `out_valid` must be low and `cc` must not have moved. For each class and sign, a one-hot mask and its complement show that exactly one bit position is consulted.

// File: rtl/fpdc_pkg.sv
package fpdc_pkg;

    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int SEL_BITS   = 12;

    // Encoding chosen so that the positive mask bit is 2*class+1.
    typedef enum logic [2:0] {
        CLS_SNAN = 3'd0,
        CLS_QNAN = 3'd1,
        CLS_INF  = 3'd2,
        CLS_SUB  = 3'd3,
        CLS_NORM = 3'd4,
        CLS_ZERO = 3'd5
    } fp_class_e;

    typedef enum logic {
        FMT_SINGLE = 1'b0,
        FMT_DOUBLE = 1'b1
    } fp_fmt_e;

    typedef struct packed {
        logic      neg;
        fp_class_e cls;
    } fp_tag_t;

    // A negative operand lowers the selected bit by one.
    function automatic logic [3:0] tag_to_index(fp_tag_t t);
        return {t.cls, ~t.neg};
    endfunction

endpackage

// File: rtl/fpdc_classify.sv
module fpdc_classify
    import fpdc_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int VAL_W = EXP_W + FRAC_W + 1
) (
    input  logic [VAL_W-1:0] value,
    output fp_tag_t          tag
);

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_min;
    logic              exp_max;
    logic              frac_nz;

    assign expo    = value[VAL_W-2 -: EXP_W];
    assign frac    = value[FRAC_W-1:0];
    assign exp_min = (expo == '0);
    assign exp_max = (expo == '1);
    assign frac_nz = |frac;

    always_comb begin
        tag.neg = value[VAL_W-1];
        if (exp_min) begin
            tag.cls = frac_nz ? CLS_SUB : CLS_ZERO;
        end else if (!exp_max) begin
            tag.cls = CLS_NORM;
        end else if (!frac_nz) begin
            tag.cls = CLS_INF;
        end else if (frac[FRAC_W-1]) begin
            tag.cls = CLS_QNAN;
        end else begin
            tag.cls = CLS_SNAN;
        end
    end

endmodule

// File: rtl/fpdc_mask_pick.sv
module fpdc_mask_pick
    import fpdc_pkg::*;
#(
    parameter int MASK_W = 16
) (
    input  fp_tag_t           tag,
    input  logic [MASK_W-1:0] mask,
    output logic              hit
);

    logic [15:0] sel_vec;
    logic [3:0]  idx;

    assign sel_vec = {{(16-SEL_BITS){1'b0}}, mask[SEL_BITS-1:0]};
    assign idx     = tag_to_index(tag);
    assign hit     = sel_vec[idx];

endmodule

// File: rtl/fp_dclass_test.sv
module fp_dclass_test
    import fpdc_pkg::*;
#(
    parameter int MASK_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              fmt,
    input  logic [63:0]       operand,
    input  logic [MASK_W-1:0] mask,
    output logic              out_valid,
    output logic [1:0]        cc
);

    localparam int SGL_W = SGL_EXP_W + SGL_FRAC_W + 1;
    localparam int DBL_W = DBL_EXP_W + DBL_FRAC_W + 1;

    fp_tag_t tag_sgl;
    fp_tag_t tag_dbl;
    fp_tag_t tag_sel;
    logic    hit;

    fpdc_classify #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) u_cls_sgl (
        .value (operand[SGL_W-1:0]),
        .tag   (tag_sgl)
    );

    fpdc_classify #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) u_cls_dbl (
        .value (operand[DBL_W-1:0]),
        .tag   (tag_dbl)
    );

    assign tag_sel = (fp_fmt_e'(fmt) == FMT_DOUBLE) ? tag_dbl : tag_sgl;

    fpdc_mask_pick #(.MASK_W(MASK_W)) u_pick (
        .tag  (tag_sel),
        .mask (mask),
        .hit  (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            cc        <= 2'd0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cc <= {1'b0, hit};
            end
        end
    end

endmodule

// File: rtl/fpdc_checker.sv
module fpdc_checker #(
    parameter int MASK_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              fmt,
    input logic [63:0]       operand,
    input logic [MASK_W-1:0] mask,
    input logic              out_valid,
    input logic [1:0]        cc
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (cc == 2'd0 && !out_valid)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R2

    AST_IDLE_HOLDS_CC: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(cc)); // R2

    AST_CC_TWO_VALUES: assert property (@(posedge clk) disable iff (rst) cc[1] == 1'b0); // R9

    AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask[11:0] == 12'h000) |=> cc == 2'd0); // R9

    AST_FULL_MASK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mask[11:0] == 12'hFFF) |=> cc == 2'd1); // R9

    AST_POS_ZERO_SGL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !fmt && operand[31:0] == 32'h0) |=> cc == {1'b0, $past(mask[11])}); // R3

endmodule

bind fp_dclass_test fpdc_checker #(.MASK_W(MASK_W)) u_chk (.*);

// File: tb/fp_dclass_test_bench.sv
`timescale 1ns/1ps
module fp_dclass_test_bench;

    localparam int MW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic          fmt;
    logic [63:0]   operand;
    logic [MW-1:0] mask;
    logic          out_valid;
    logic [1:0]    cc;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fp_dclass_test #(.MASK_W(MW)) u_fp_dclass_test (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt(fmt),
        .operand(operand), .mask(mask), .out_valid(out_valid), .cc(cc)
    );

    // kind: 0 zero, 1 normal, 2 subnormal, 3 inf, 4 qnan, 5 snan
    function automatic int kind_bit(int kind, bit neg);
        int hi;
        case (kind)
            0: hi = 11;
            1: hi = 9;
            2: hi = 7;
            3: hi = 5;
            4: hi = 3;
            default: hi = 1;
        endcase
        return neg ? hi - 1 : hi;
    endfunction

    function automatic string kind_req(int kind);
        case (kind)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Independent reference from the requirement text.
    function automatic int ref_kind(bit f, logic [63:0] op);
        logic [10:0] e;
        logic [51:0] fr;
        bit emax, emin, qb;
        if (f) begin
            e = op[62:52]; fr = op[51:0];
            emax = (e == 11'h7FF); emin = (e == 11'h0); qb = op[51];
        end else begin
            e = {3'b0, op[30:23]}; fr = {29'b0, op[22:0]};
            emax = (op[30:23] == 8'hFF); emin = (op[30:23] == 8'h0); qb = op[22];
        end
        if (emin) return (fr == 0) ? 0 : 2;
        if (!emax) return 1;
        if (fr == 0) return 3;
        return qb ? 4 : 5;
    endfunction

    function automatic logic [1:0] ref_cc(bit f, logic [63:0] op, logic [MW-1:0] m);
        bit neg;
        neg = f ? op[63] : op[31];
        return {1'b0, m[kind_bit(ref_kind(f, op), neg)]};
    endfunction

    function automatic logic [63:0] make_op(bit f, int kind, bit neg);
        logic [63:0] r;
        logic [63:0] junk;
        junk = {$urandom, $urandom};
        if (f) begin
            case (kind)
                0: r = 64'h0;
                1: r = {1'b0, 11'($urandom_range(1, 2046)), junk[51:0]};
                2: r = {1'b0, 11'h0, junk[51:1], 1'b1};
                3: r = {1'b0, 11'h7FF, 52'h0};
                4: r = {1'b0, 11'h7FF, 1'b1, junk[50:0]};
                default: r = {1'b0, 11'h7FF, 1'b0, junk[50:1], 1'b1};
            endcase
            r[63] = neg;
        end else begin
            case (kind)
                0: r[31:0] = 32'h0;
                1: r[31:0] = {1'b0, 8'($urandom_range(1, 254)), junk[22:0]};
                2: r[31:0] = {1'b0, 8'h0, junk[22:1], 1'b1};
                3: r[31:0] = {1'b0, 8'hFF, 23'h0};
                4: r[31:0] = {1'b0, 8'hFF, 1'b1, junk[21:0]};
                default: r[31:0] = {1'b0, 8'hFF, 1'b0, junk[21:1], 1'b1};
            endcase
            r[31]    = neg;
            r[63:32] = junk[63:32];   // upper half must not matter (R10)
        end
        return r;
    endfunction

    task automatic check(string req, logic [1:0] got, logic [1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive at falling edge, result is due after the next rising edge.
    task automatic apply(bit f, logic [63:0] op, logic [MW-1:0] m, string req);
        logic [1:0] exp;
        exp      = ref_cc(f, op, m);
        fmt      = f;
        operand  = op;
        mask     = m;
        in_valid = 1'b1;
        @(negedge clk);
        check(req, cc, exp);
        check("R2", {1'b0, out_valid}, 2'd1);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] held;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; in_valid = 1'b0; fmt = 1'b0; operand = '0; mask = '0;
        repeat (3) @(negedge clk);
        check("R1", cc, 2'd0);
        check("R1", {1'b0, out_valid}, 2'd0);
        rst = 1'b0;
        @(negedge clk);

        // One-hot and complement masks for each class, sign and format.
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < 6; k++) begin
                for (int s = 0; s < 2; s++) begin
                    logic [63:0] op;
                    logic [MW-1:0] oh;
                    op = make_op(f[0], k, s[0]);
                    oh = '0;
                    oh[kind_bit(k, s[0])] = 1'b1;
                    apply(f[0], op, oh, kind_req(k));
                    check(kind_req(k), cc, 2'd1);
                    apply(f[0], op, {4'hF, ~oh[11:0]}, kind_req(k));
                    check(kind_req(k), cc, 2'd0);
                end
            end
        end

        // R9: empty and full masks.
        apply(1'b1, make_op(1'b1, 1, 1'b1), 16'h0000, "R9");
        check("R9", cc, 2'd0);
        apply(1'b0, make_op(1'b0, 5, 1'b0), 16'h0FFF, "R9");
        check("R9", cc, 2'd1);

        // R11: upper mask bits alone do nothing.
        apply(1'b0, make_op(1'b0, 0, 1'b0), 16'hF000, "R11");
        check("R11", cc, 2'd0);

        // R10: a double-shaped infinity read as single is a zero.
        apply(1'b0, 64'h7FF0_0000_0000_0000, 16'h0800, "R10");
        check("R10", cc, 2'd1);
        apply(1'b1, 64'h7FF0_0000_0000_0000, 16'h0020, "R10");
        check("R10", cc, 2'd1);

        // R2: idle cycles hold cc and drop out_valid.
        held = cc;
        operand = 64'h0; mask = 16'h0000; fmt = 1'b0;
        @(negedge clk);
        check("R2", cc, held);
        check("R2", {1'b0, out_valid}, 2'd0);

        // Constrained random mix.
        for (int i = 0; i < 400; i++) begin
            bit rf;
            int rk;
            logic [63:0] op;
            rf = 1'($urandom);
            rk = int'($urandom_range(0, 6));
            op = (rk == 6) ? {$urandom, $urandom} : make_op(rf, rk, 1'($urandom));
            apply(rf, op, MW'($urandom), (rk == 6) ? "R9" : kind_req(rk));
            if (($urandom & 3) == 0) begin
                held = cc;
                @(negedge clk);
                check("R2", cc, held);
            end
        end

        // R1: reset mid-run.
        apply(1'b0, 32'h0, 16'h0800, "R3");
        rst = 1'b1;
        @(negedge clk);
        check("R1", cc, 2'd0);
        rst = 1'b0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule